// File: doc/BRIEF.md
# Bit-Serial Complex Sample Receiver

This block takes complex samples arriving one bit at a time on a single data pin. A serial clock and a frame strobe travel with the data. Each sample is an in-phase word followed by a quadrature word, both 16 bits wide, most significant bit first. The block rebuilds the two words and passes them to the system clock domain as one registered pair with a single-cycle valid pulse.

The serial clock is never used as a clock. All three serial pins go through a two-flop synchronizer in the system clock domain, and the programmed edge of the serial clock is found there. The system clock must therefore run well above the serial bit rate.

Three static configuration inputs control the behaviour:
- the serial clock edge that captures data (rising or falling);
- the active level of the frame strobe;
- the framing mode. In pulse mode the strobe flags the first bit of a sample. In window mode the strobe gates every bit.

Top module: `serrx_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `smp_valid` is 0 and `smp_i` and `smp_q` are 0.
- R2: A data bit is captured at a serial clock rising edge when `cfg_fall_edge` = 0, and at a falling edge when `cfg_fall_edge` = 1. Edges of the other direction capture nothing.
- R3: The frame strobe is active at level 1 when `cfg_strb_low` = 0, and at level 0 when `cfg_strb_low` = 1.
- R4: In pulse mode (`cfg_window` = 0), a captured bit with the strobe active is bit 0 of a new sample. Bits captured with the strobe inactive and no sample in progress are ignored.
- R5: In pulse mode, an active strobe on a bit in the middle of a sample drops the partial sample and restarts counting with that bit as bit 0.
- R6: In window mode (`cfg_window` = 1), only bits captured while the strobe is active are taken. A bit captured with the strobe inactive is skipped, and the bit count in progress is kept.
- R7: Of the 32 bits taken for a sample, the first 16 form `smp_i` and the last 16 form `smp_q`, each MSB first.
- R8: `smp_valid` is high for exactly one cycle per complete sample. It rises after the third system clock rising edge, counting from the edge that first samples the serial clock at its post-capture level.
- R9: `smp_i` and `smp_q` change only in the cycle in which `smp_valid` is high, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fall_edge | input | 1 | 1 selects falling serial clock edge for capture |
| cfg_strb_low | input | 1 | 1 makes the frame strobe active low |
| cfg_window | input | 1 | 1 selects window framing, 0 selects pulse framing |
| ser_clk | input | 1 | Serial bit clock, asynchronous to `clk` |
| ser_frm | input | 1 | Frame strobe |
| ser_dat | input | 1 | Serial data, I then Q, MSB first |
| smp_valid | output | 1 | One-cycle pulse when a new sample is presented |
| smp_i | output | 16 | In-phase word of the latest sample |
| smp_q | output | 16 | Quadrature word of the latest sample |

## Verification
The assertions assume three things about the inputs:
- the configuration inputs change only while reset is held;
- each serial clock level lasts at least two system clock cycles;
- data and strobe are stable from well before the capturing edge until the synchronizer has seen that edge.

Under these conditions one detected edge can never follow another directly, and a valid pulse can never repeat on the next cycle. The stimulus meets them by driving every serial phase for four system clocks and by changing data and strobe only at the return to the idle clock level. The configuration is set under reset for each scenario.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    localparam int SMP_W = 16;
    localparam int PAIR_W = 2 * SMP_W;

    typedef enum logic {
        FRM_PULSE  = 1'b0,
        FRM_WINDOW = 1'b1
    } frm_mode_e;

    typedef struct packed {
        logic stb;
        logic dat;
        logic mark;
    } bit_ev_t;

    typedef struct packed {
        logic [SMP_W-1:0] i;
        logic [SMP_W-1:0] q;
    } cplx_t;

    function automatic cplx_t split_pair(input logic [PAIR_W-1:0] v);
        cplx_t r;
        r.i = v[PAIR_W-1:SMP_W];
        r.q = v[SMP_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/serrx_front.sv
module serrx_front
    import serrx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fall_edge,
    input  logic    strb_low,
    input  logic    ser_clk,
    input  logic    ser_frm,
    input  logic    ser_dat,
    output bit_ev_t ev
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] ck_q;
    logic [TOP:0] fr_q;
    logic [TOP:0] dt_q;
    logic         ck_old;
    logic         rise;
    logic         fall;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_q <= '0;
                    fr_q <= '0;
                    dt_q <= '0;
                end else begin
                    ck_q <= ser_clk;
                    fr_q <= ser_frm;
                    dt_q <= ser_dat;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_q <= '0;
                    fr_q <= '0;
                    dt_q <= '0;
                end else begin
                    ck_q <= {ck_q[TOP-1:0], ser_clk};
                    fr_q <= {fr_q[TOP-1:0], ser_frm};
                    dt_q <= {dt_q[TOP-1:0], ser_dat};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ck_old <= 1'b0;
        else     ck_old <= ck_q[TOP];
    end

    always_comb begin
        rise    = ck_q[TOP] & ~ck_old;
        fall    = ~ck_q[TOP] & ck_old;
        ev.stb  = fall_edge ? fall : rise;
        ev.dat  = dt_q[TOP];
        ev.mark = fr_q[TOP] ^ strb_low;
    end

    // R2: a detected edge needs a level change, so two never come back to back
    p_single_edge_r2: assert property (@(posedge clk) disable iff (rst)
        ev.stb |=> !ev.stb);

endmodule

// File: rtl/serrx_deser.sv
module serrx_deser
    import serrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  frm_mode_e mode,
    input  bit_ev_t   ev,
    output logic      valid,
    output cplx_t     word
);

    localparam int CW = $clog2(PAIR_W + 1);
    localparam logic [CW-1:0] LAST = CW'(PAIR_W - 1);

    logic [CW-1:0]     cnt;
    logic [PAIR_W-1:0] sh;
    logic [PAIR_W-1:0] nxt;
    logic              take;
    logic              restart;

    always_comb begin
        nxt     = {sh[PAIR_W-2:0], ev.dat};
        restart = (mode == FRM_PULSE) && ev.mark;
        if (mode == FRM_WINDOW) take = ev.stb && ev.mark;
        else                    take = ev.stb && (ev.mark || (cnt != '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sh    <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (take) begin
                sh <= nxt;
                if (restart) begin
                    cnt <= CW'(1);
                end else if (cnt == LAST) begin
                    cnt   <= '0;
                    word  <= split_pair(nxt);
                    valid <= 1'b1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // R8: one pulse per sample, never on two cycles in a row
    p_valid_gap_r8: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R5: a pulse-mode strobe always puts the count just past bit 0
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (ev.stb && mode == FRM_PULSE && ev.mark) |=> (cnt == CW'(1)));

    // R6: a window-mode bit outside the window leaves the count alone
    p_window_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ev.stb && mode == FRM_WINDOW && !ev.mark) |=> $stable(cnt));

    // R2: without a detected edge nothing is counted
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ev.stb |=> $stable(cnt));

    // R7: the count never reaches the sample length
    p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R9: the sample word moves only together with the valid pulse
    p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(word));

endmodule

// File: rtl/serrx_top.sv
module serrx_top
    import serrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_fall_edge,
    input  logic             cfg_strb_low,
    input  logic             cfg_window,
    input  logic             ser_clk,
    input  logic             ser_frm,
    input  logic             ser_dat,
    output logic             smp_valid,
    output logic [SMP_W-1:0] smp_i,
    output logic [SMP_W-1:0] smp_q
);

    bit_ev_t   ev;
    cplx_t     word;
    frm_mode_e mode;

    assign mode = frm_mode_e'(cfg_window);

    serrx_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst       (rst),
        .fall_edge (cfg_fall_edge),
        .strb_low  (cfg_strb_low),
        .ser_clk   (ser_clk),
        .ser_frm   (ser_frm),
        .ser_dat   (ser_dat),
        .ev        (ev)
    );

    serrx_deser u_deser (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .ev    (ev),
        .valid (smp_valid),
        .word  (word)
    );

    assign smp_i = word.i;
    assign smp_q = word.q;

    // R1: the first cycle after reset shows an empty output
    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!smp_valid && smp_i == '0 && smp_q == '0));

endmodule

// File: tb/sim_serrx_top.sv
module sim_serrx_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_fall_edge = 1'b0;
    logic        cfg_strb_low = 1'b0;
    logic        cfg_window = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_frm = 1'b0;
    logic        ser_dat = 1'b0;
    logic        smp_valid;
    logic [15:0] smp_i;
    logic [15:0] smp_q;

    int n_vec  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    serrx_top u0 (
        .clk           (clk),
        .rst           (rst),
        .cfg_fall_edge (cfg_fall_edge),
        .cfg_strb_low  (cfg_strb_low),
        .cfg_window    (cfg_window),
        .ser_clk       (ser_clk),
        .ser_frm       (ser_frm),
        .ser_dat       (ser_dat),
        .smp_valid     (smp_valid),
        .smp_i         (smp_i),
        .smp_q         (smp_q)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: input history plus a bit counter
    logic [3:0]  h_ck, h_fr, h_dt;
    int          m_cnt;
    logic [31:0] m_sh;
    logic [31:0] m_word;
    logic        m_val;

    always @(posedge clk) begin
        bit edge_seen, mark, take;
        if (rst) begin
            h_ck = '0; h_fr = '0; h_dt = '0;
            m_cnt = 0; m_sh = '0; m_word = '0; m_val = 1'b0;
        end else begin
            h_ck = {h_ck[2:0], ser_clk};
            h_fr = {h_fr[2:0], ser_frm};
            h_dt = {h_dt[2:0], ser_dat};
            m_val = 1'b0;
            edge_seen = cfg_fall_edge ? (h_ck[3] && !h_ck[2]) : (h_ck[2] && !h_ck[3]);
            mark = h_fr[2] ^ cfg_strb_low;
            if (cfg_window) take = edge_seen && mark;
            else            take = edge_seen && (mark || m_cnt != 0);
            if (take) begin
                m_sh = {m_sh[30:0], h_dt[2]};
                if (!cfg_window && mark) begin
                    m_cnt = 1;
                end else begin
                    m_cnt++;
                    if (m_cnt == 32) begin
                        m_cnt = 0;
                        m_word = m_sh;
                        m_val = 1'b1;
                    end
                end
            end
        end
    end

    logic [31:0] expq[$];
    int          got_words = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(smp_valid == m_val, "R8 valid timing", {31'b0, smp_valid}, {31'b0, m_val});
            chk({smp_i, smp_q} == m_word, "R9 output word vs model", {smp_i, smp_q}, m_word);
            if (smp_valid) begin
                got_words++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 unexpected sample", {smp_i, smp_q}, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    chk({smp_i, smp_q} == e, "R7 I/Q word order", {smp_i, smp_q}, e);
                end
            end
        end
    end

    function automatic logic idle_lvl();
        return cfg_fall_edge;
    endfunction

    task automatic send_bit(input logic b, input logic act);
        ser_dat = b;
        ser_frm = act ^ cfg_strb_low;
        repeat (4) @(negedge clk);
        ser_clk = ~idle_lvl();
        repeat (4) @(negedge clk);
        ser_clk = idle_lvl();
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int k = 31; k >= 0; k--)
            send_bit(w[k], cfg_window ? 1'b1 : (k == 31));
        ser_frm = cfg_strb_low;
    endtask

    task automatic start(input logic fe, input logic sl, input logic win);
        @(negedge clk);
        rst = 1'b1;
        cfg_fall_edge = fe;
        cfg_strb_low = sl;
        cfg_window = win;
        ser_clk = fe;
        ser_frm = sl;
        ser_dat = 1'b0;
        got_words = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: first sampled cycle after reset
        chk(smp_valid == 1'b0, "R1 reset valid", {31'b0, smp_valid}, 32'h0);
        chk({smp_i, smp_q} == 32'h0, "R1 reset word", {smp_i, smp_q}, 32'h0);
    endtask

    task automatic finish_scn(input string req, input int n_exp);
        repeat (16) @(negedge clk);
        chk(expq.size() == 0, req, expq.size(), 32'h0);
        chk(got_words == n_exp, req, got_words, n_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        // R2 R3 R4: rising edge, high strobe, pulse framing
        start(1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 5; k++) send_bit(1'b1, 1'b0); // R4 stray bits ignored
        expq.push_back(32'h8000_0001); send_word(32'h8000_0001);
        expq.push_back(32'hFFFF_0000); send_word(32'hFFFF_0000);
        expq.push_back(32'h1234_ABCD); send_word(32'h1234_ABCD);
        finish_scn("R4 pulse rising", 3);

        // R2 R3: falling edge, low strobe, pulse framing
        start(1'b1, 1'b1, 1'b0);
        expq.push_back(32'hA5C3_0F96); send_word(32'hA5C3_0F96);
        expq.push_back(32'h0001_8000); send_word(32'h0001_8000);
        finish_scn("R3 pulse falling low strobe", 2);

        // R5: a strobe mid-sample restarts the count
        start(1'b0, 1'b0, 1'b0);
        for (int k = 31; k >= 22; k--) send_bit(1'b1, k == 31);
        expq.push_back(32'h5A5A_C3C3); send_word(32'h5A5A_C3C3);
        for (int k = 31; k >= 1; k--) send_bit(1'b0, k == 31);
        expq.push_back(32'h7FFF_FFFE); send_word(32'h7FFF_FFFE);
        finish_scn("R5 mid-sample restart", 2);

        // R6: window framing with a gap between I and Q
        start(1'b0, 1'b0, 1'b1);
        expq.push_back(32'hDEAD_BEEF);
        for (int k = 31; k >= 16; k--) send_bit(32'hDEAD_BEEF >> k, 1'b1);
        for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b0);
        for (int k = 15; k >= 0; k--) send_bit(32'hDEAD_BEEF >> k, 1'b1);
        ser_frm = 1'b0;
        expq.push_back(32'h0F0F_1111); send_word(32'h0F0F_1111);
        finish_scn("R6 window gap", 2);

        // R6 R3 R2: window framing, falling edge, low strobe
        start(1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++) send_bit(1'b1, 1'b0);
        expq.push_back(32'h3C3C_8421); send_word(32'h3C3C_8421);
        finish_scn("R6 window falling low strobe", 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule